// File: doc/BRIEF.md
# Active-Low Interrupt Status Controller

This block gathers the interrupt sources of a peripheral onto one active-low request line for the CPU. Software controls it through a write-only enable register and watches it through a status register. In the status register a cleared bit marks a pending source. Most sources are latched: an event pulse on a source that is enabled sets a single pending flag. The flag stays set until software writes 0 to that source's enable bit, and that write also forces the status bit back to its inactive value of 1.

One source behaves differently. The transmit-complete source, at bit 3, is not latched. Its status bit follows the transmitter idle level directly, and its enable bit does not affect the readout. Its enable bit decides only whether that idle level can pull the request line low. The other fixed positions are serial input ready at bit 5 and output data needed at bit 4. The remaining positions hold timer and key sources, which all behave as ordinary latched sources.

Top module: `irqstat_top`

## Requirements
- R1: Status bit i reads 0 while latched source i is pending and 1 while it is not.
- R2: A latched source becomes pending on the clock edge at which its event pulse is sampled while its enable bit is already 1. An event on a source whose enable bit is 0 is ignored, and its status stays 1.
- R3: Writing 0 to an enable bit clears that source's pending flag at the write edge, even when an event arrives in the same cycle. The status bit then stays 1, ignoring events, until the bit is enabled again.
- R4: Status bit 3 equals the inverse of the transmitter idle input whatever its enable bit holds. Event input bit 3 has no effect.
- R5: Writing 1 to enable bit 3 while the transmitter is idle drives the request line low from the cycle after the write.
- R6: The request line is low exactly when some enabled latched source is pending, or when enable bit 3 is 1 and the transmitter is idle. It stays low until every such condition is gone.
- R7: A source holds at most one pending flag. After several events, one disable clears it, and enabling it again does not bring it back without a new event.
- R8: Reset clears every enable bit. After reset all latched status bits read 1 and the request line is high.
- R9: A write that leaves an enable bit at 1 does not disturb that source's pending flag. An event that arrives in the same cycle as the write enabling its source is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enWrite | input | 1 | Strobe that loads the enable register |
| enData | input | 8 | New enable value |
| srcEvent | input | 8 | One-cycle event pulses, one per latched source |
| txIdle | input | 1 | Level that is high while the transmitter is idle |
| statusOut | output | 8 | Status readout, 0 means pending |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The bench targets the same-cycle collisions. One case is a disabling write that meets an event; a design that let the set win would leave a stale request. Another is an enabling write that meets an event; a design that used the new enable would capture an event the source never saw enabled. It checks that status bit 3 follows the idle level with its enable off, where a latched or gated version would read wrong. It also checks that a kept enable bit does not acknowledge, since a design that cleared pending flags on every write would drop requests. Random traffic against a reference model covers any stuck request line and any request counting.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;
  localparam int SRC_COUNT   = 8;
  localparam int TX_DONE_IDX = 3;

  typedef struct packed {
    logic [SRC_COUNT-1:0] clrMask; // sources acknowledged at this edge
    logic [SRC_COUNT-1:0] armMask; // sources allowed to latch this edge
    logic                 txArm;   // transmit-complete may request
  } ctrlStrobes_t;
endpackage

// File: rtl/irqstat_ctrl.sv
module irqstat_ctrl
  import irqstat_pkg::*;
#(
  parameter int NUM_SRC = SRC_COUNT,
  parameter int TX_IDX  = TX_DONE_IDX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enWrite,
  input  logic [NUM_SRC-1:0] enData,
  output ctrlStrobes_t       strobes
);
  logic [NUM_SRC-1:0] enQ;

  always_ff @(posedge clk) begin
    if (!rst_n)       enQ <= '0;
    else if (enWrite) enQ <= enData;
  end

  always_comb begin
    strobes         = '0;
    strobes.armMask = enQ;
    strobes.clrMask = enWrite ? ~enData : '0;
    strobes.txArm   = enQ[TX_IDX];
  end

  // R8: enables are cleared coming out of reset
  a_r8_reset_disables: assert property (@(posedge clk)
    $rose(rst_n) |-> (enQ == '0));

  // R9: a write that keeps a bit at 1 never acknowledges it
  a_r9_keep_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (enWrite && (enData == enQ)) |-> ((strobes.clrMask & enQ) == '0));
endmodule

// File: rtl/irqstat_dp.sv
module irqstat_dp
  import irqstat_pkg::*;
#(
  parameter int NUM_SRC = SRC_COUNT,
  parameter int TX_IDX  = TX_DONE_IDX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       strobes,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               txIdle,
  output logic [NUM_SRC-1:0] statusOut,
  output logic               irqN
);
  logic [NUM_SRC-1:0] pendQ;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == TX_IDX) begin : g_level
      assign pendQ[i]     = 1'b0;
      assign statusOut[i] = ~txIdle;
    end else begin : g_latched
      logic pendBit;
      always_ff @(posedge clk) begin
        if (!rst_n)                   pendBit <= 1'b0;
        else if (strobes.clrMask[i])  pendBit <= 1'b0;
        else if (strobes.armMask[i] && srcEvent[i]) pendBit <= 1'b1;
      end
      assign pendQ[i]     = pendBit;
      assign statusOut[i] = ~pendBit;

      // R3: acknowledge beats a colliding event
      a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        strobes.clrMask[i] |=> statusOut[i]);
      // R2: an enabled event latches at that edge
      a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes.armMask[i] && srcEvent[i] && !strobes.clrMask[i]) |=> !statusOut[i]);
      // R2: a disabled source can never become pending
      a_r2_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobes.armMask[i] && statusOut[i]) |=> statusOut[i]);
    end
  end

  assign irqN = ~(|pendQ | (strobes.txArm & txIdle));
endmodule

// File: rtl/irqstat_top.sv
module irqstat_top
  import irqstat_pkg::*;
#(
  parameter int NUM_SRC = SRC_COUNT,
  parameter int TX_IDX  = TX_DONE_IDX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enWrite,
  input  logic [NUM_SRC-1:0] enData,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               txIdle,
  output logic [NUM_SRC-1:0] statusOut,
  output logic               irqN
);
  ctrlStrobes_t strobes;

  irqstat_ctrl #(.NUM_SRC(NUM_SRC), .TX_IDX(TX_IDX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enWrite(enWrite), .enData(enData),
    .strobes(strobes)
  );

  irqstat_dp #(.NUM_SRC(NUM_SRC), .TX_IDX(TX_IDX)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .srcEvent(srcEvent),
    .txIdle(txIdle), .statusOut(statusOut), .irqN(irqN)
  );

  // R4: transmit-complete status tracks the idle level
  a_r4_tx_level: assert property (@(posedge clk) disable iff (!rst_n)
    statusOut[TX_IDX] == !txIdle);

  // R6: a request always has some status bit showing pending
  a_r6_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    !irqN |-> (statusOut != '1));

  // R5: enabling transmit-complete while idle requests next cycle
  a_r5_tx_enable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (enWrite && enData[TX_IDX] && txIdle) |=> (!irqN || !txIdle));
endmodule

// File: tb/irqstat_top_bench.sv
module irqstat_top_bench;
  localparam int N  = 8;
  localparam int TX = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enWrite = 1'b0;
  logic [N-1:0] enData = '0;
  logic [N-1:0] srcEvent = '0;
  logic txIdle = 1'b1;
  logic [N-1:0] statusOut;
  logic irqN;

  int errors = 0;
  int checks = 0;
  logic [N-1:0] mEn = '0;
  logic [N-1:0] mPend = '0;

  always #10 clk = ~clk;

  irqstat_top u_irqstat_top (
    .clk(clk), .rst_n(rst_n), .enWrite(enWrite), .enData(enData),
    .srcEvent(srcEvent), .txIdle(txIdle), .statusOut(statusOut), .irqN(irqN)
  );

  function automatic logic [N-1:0] expStatus(logic [N-1:0] p, logic idle);
    logic [N-1:0] s;
    s = ~p;
    s[TX] = ~idle;
    return s;
  endfunction

  function automatic logic expIrqN(logic [N-1:0] p, logic [N-1:0] e, logic idle);
    return !((|p) || (e[TX] && idle));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive inputs, update model at the edge, leave at negedge
  task automatic step(logic w, logic [N-1:0] d, logic [N-1:0] ev, logic idle);
    logic [N-1:0] nEn;
    enWrite = w; enData = d; srcEvent = ev; txIdle = idle;
    @(posedge clk);
    nEn = w ? d : mEn;
    mPend = (mPend | (ev & mEn)) & nEn;
    mPend[TX] = 1'b0;
    mEn = nEn;
    @(negedge clk);
    enWrite = 1'b0; srcEvent = '0;
  endtask

  task automatic chkAll(string req);
    chk({req, " status"}, 32'(statusOut), 32'(expStatus(mPend, txIdle)));
    chk({req, " irqN"}, 32'(irqN), 32'(expIrqN(mPend, mEn, txIdle)));
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mEn = '0; mPend = '0;
    // R8 reset state
    chk("R8 status", 32'(statusOut), 32'hF7);
    chk("R8 irqN", 32'(irqN), 32'd1);

    // R2 event on disabled source ignored
    step(0, '0, 8'h20, 1'b0);
    chk("R2 disabled", 32'(statusOut[5]), 32'd1);
    chk("R2 disabled irq", 32'(irqN), 32'd1);

    // R9 event in the same cycle as enabling is not captured
    step(1, 8'h30, 8'h20, 1'b0);
    chk("R9 same-cycle enable", 32'(statusOut[5]), 32'd1);
    // R2 enabled event latches, R1 reads 0
    step(0, '0, 8'h20, 1'b0);
    chk("R1 pending reads 0", 32'(statusOut), 32'hDF | 32'h08);
    chk("R6 irq low", 32'(irqN), 32'd0);
    // R7 multiple events, plus bit 4
    step(0, '0, 8'h20, 1'b0);
    step(0, '0, 8'h30, 1'b0);
    chkAll("R7");
    // R9 rewrite keeps both pending
    step(1, 8'h30, '0, 1'b0);
    chk("R9 keep", 32'(statusOut[5:4]), 32'd0);
    // R6 drop bit5, bit4 still requests
    step(1, 8'h10, '0, 1'b0);
    chk("R3 bit5 inactive", 32'(statusOut[5]), 32'd1);
    chk("R6 still low", 32'(irqN), 32'd0);
    // R3 disable all, release
    step(1, 8'h00, 8'h10, 1'b0);
    chk("R3 all clear", 32'(statusOut), 32'hFF);
    chk("R6 released", 32'(irqN), 32'd1);
    // R7 re-enable does not revive
    step(1, 8'h30, '0, 1'b0);
    chk("R7 no revive", 32'(statusOut), 32'hFF);
    chk("R7 irq", 32'(irqN), 32'd1);

    // R4 idle level visible with enable off, bit3 event ignored
    step(1, 8'h00, 8'h08, 1'b1);
    chk("R4 level", 32'(statusOut), 32'hF7);
    chk("R4 no request", 32'(irqN), 32'd1);
    // R5 enable while idle
    step(1, 8'h08, '0, 1'b1);
    chk("R5 immediate", 32'(irqN), 32'd0);
    step(0, '0, '0, 1'b0);
    chk("R4 busy", 32'(statusOut[3]), 32'd1);
    chk("R6 busy releases", 32'(irqN), 32'd1);

    // R3 disable colliding with event
    step(1, 8'h01, '0, 1'b0);
    step(1, 8'h00, 8'h01, 1'b0);
    chk("R3 collision", 32'(statusOut[0]), 32'd1);

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic w;
      w = ($urandom % 4) == 0;
      step(w, N'($urandom), N'($urandom & $urandom), 1'($urandom));
      chkAll("R6 random");
    end

    // R8 reset mid-run
    step(1, 8'hFF, 8'hFF, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mEn = '0; mPend = '0;
    chk("R8 rerun status", 32'(statusOut), 32'hF7);
    chk("R8 rerun irqN", 32'(irqN), 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule